// File: doc/BRIEF.md
# SPI Master Controller with Status Flags

This block is a byte-wide serial peripheral interface master for a small microcontroller. A CPU reaches it through three registers on a simple register bus: control, status and data. Writing the data register while the controller is enabled shifts eight bits out on MOSI, most significant bit first, and eight bits in from MISO at the same time. The serial clock runs at the system clock divided by 2, 4, 16 or 32, with a selectable idle level and phase.

When the eighth bit is done, the block sets a completion flag and, if enabled, raises an interrupt request. A data write that arrives while a byte is still moving is dropped and flags a collision. An active-low select output frames each transfer in master mode, and a low level on the external select input in master mode raises a mode-fault flag. Flags are cleared by a two-step sequence: a status read records which flags are set, and the next data-register access clears exactly those.

The bus is synchronous: `reg_sel` picks the register, `rd_en` or `wr_en` qualifies one clock cycle, and `rd_data` shows the selected register in the same cycle. `ss_n_in` is taken to be synchronous to `clk`.

Top module: `spi_ctl_top`

## Requirements
- R1: After reset the control register and status register read 0x00, sck is 0, ss_n_out is 1 and irq is 0.
- R2: The control register reads back what was written; its bits are, MSB first, interrupt enable (7), controller enable (6), open-drain option (5, stored only), master select (4), clock polarity (3), clock phase (2) and rate code (1:0). Rate codes 0, 1, 2, 3 give one bit every 2, 4, 16 or 32 clock cycles.
- R3: The status register (address 1) holds the completion flag in bit 7, the collision flag in bit 6 and the mode-fault flag in bit 4, with all other bits 0; a write to it changes nothing.
- R4: A data-register write (address 2) while the enable bit is clear starts no transfer and changes no flag.
- R5: A data-register write during a transfer leaves that transfer's timing and data untouched and sets the collision flag.
- R6: A transfer shifts the written byte out on mosi MSB first, each bit lasting two half periods, and ends 16 half periods after the write; ss_n_out is low for exactly that span in master mode.
- R7: At the end of the transfer the completion flag sets; irq is high while the completion flag and the interrupt enable bit are both set.
- R8: After a status read, the next data read, or data write with the controller enabled, clears exactly the flags seen by that read; a flag set after the status read survives, and a data access with no preceding status read clears nothing.
- R9: sck rests at the polarity bit; with phase 0 the first edge comes in the middle of the first bit, with phase 1 at its start.
- R10: mosi changes and MISO is sampled at opposite half-bit boundaries; the sampled byte is returned on data-register reads (address 2).
- R11: The mode-fault flag sets when ss_n_in is low while master select is set.
- R12: Reset during a transfer cancels it: ss_n_out returns high, the control register clears and no completion flag appears later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| rd_en | input | 1 | Read strobe for one cycle |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Selected register contents |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n_out | output | 1 | Active-low select frame for the transfer |
| ss_n_in | input | 1 | External active-low select, feeds mode fault |

## Verification
Register reads are combinational, so the bench samples `rd_data` one time step after presenting a read. A data write takes effect at the clock edge that accepts it; half period k of the transfer then occupies the k-th group of H cycles after that edge, H being half the bit period, so the bench checks mosi and sck once at the start of every half and holds MISO steady across each bit so its sample edge cannot be missed. The completion flag, the end of the select frame and the received byte are all due exactly 16·H cycles after the accepting edge, and the bench reads them at that point rather than polling, so a transfer that is one half too long or restarted by a colliding write shows up as a miscompare.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

  localparam int BYTE_W = 8;
  localparam int HALF_N = 2 * BYTE_W;
  localparam int HALF_W = $clog2(HALF_N);
  localparam int DIV_W  = 5;
  localparam int FLAG_N = 3;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic       irq_en;
    logic       sys_en;
    logic       open_drain;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // flag vector order: [2] complete, [1] collision, [0] mode fault
  localparam int F_DONE = 2;
  localparam int F_COLL = 1;
  localparam int F_MODF = 0;

  // clock cycles per half bit for each rate code
  function automatic logic [DIV_W-1:0] half_cycles(input logic [1:0] code);
    logic [DIV_W-1:0] n;
    case (code)
      2'd0:    n = DIV_W'(1);
      2'd1:    n = DIV_W'(2);
      2'd2:    n = DIV_W'(8);
      default: n = DIV_W'(16);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick
  import spi_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] rate_code,
  input  logic       run,
  output logic       tick
);

  logic [DIV_W-1:0] span_q, span_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end = (cnt_q == span_q - DIV_W'(1));
  assign tick   = run && at_end;

  always_comb begin
    span_d = span_q;
    cnt_d  = cnt_q;
    if (load) begin
      span_d = half_cycles(rate_code);
      cnt_d  = '0;
    end else if (run) begin
      if (at_end) cnt_d = '0;
      else        cnt_d = cnt_q + DIV_W'(1);
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q <= DIV_W'(1);
      cnt_q  <= '0;
    end else begin
      span_q <= span_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);  // R2

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tick,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              sck,
  output logic              mosi,
  output logic [BYTE_W-1:0] rx_byte
);

  logic              busy_q, busy_d;
  logic [HALF_W-1:0] half_q, half_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] rsh_q, rsh_d;
  logic [BYTE_W-1:0] rbuf_q, rbuf_d;
  logic              last_half;

  assign last_half = (half_q == HALF_W'(HALF_N - 1));
  assign done      = busy_q && tick && last_half;
  assign busy      = busy_q;
  assign mosi      = tx_q[BYTE_W-1];
  assign rx_byte   = rbuf_q;
  // even halves: phase 0 at rest level, phase 1 at active level
  assign sck       = busy_q ? (cpol ^ half_q[0] ^ cpha) : cpol;

  always_comb begin
    busy_d = busy_q;
    half_d = half_q;
    tx_d   = tx_q;
    rsh_d  = rsh_q;
    rbuf_d = rbuf_q;
    if (start) begin
      busy_d = 1'b1;
      half_d = '0;
      tx_d   = tx_byte;
    end else if (busy_q && tick) begin
      half_d = half_q + HALF_W'(1);
      if (!half_q[0]) begin
        rsh_d = {rsh_q[BYTE_W-2:0], miso};
      end else begin
        tx_d = {tx_q[BYTE_W-2:0], 1'b0};
        if (last_half) begin
          busy_d = 1'b0;
          rbuf_d = rsh_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      half_q <= '0;
      tx_q   <= '0;
      rsh_q  <= '0;
      rbuf_q <= '0;
    end else begin
      busy_q <= busy_d;
      half_q <= half_d;
      tx_q   <= tx_d;
      rsh_q  <= rsh_d;
      rbuf_q <= rbuf_d;
    end
  end

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !tick |=> $stable(tx_q) && $stable(half_q));  // R5

  AST_DONE_ENDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);  // R6

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start, done}));  // R6

endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] set_evt,
  input  logic              stat_rd,
  input  logic              data_acc,
  input  logic              irq_en,
  output logic [FLAG_N-1:0] flags,
  output logic              irq
);

  logic [FLAG_N-1:0] flg_q, flg_d;
  logic [FLAG_N-1:0] cap_q, cap_d;
  logic [FLAG_N-1:0] clr;

  assign clr   = data_acc ? cap_q : '0;
  assign flags = flg_q;
  assign irq   = flg_q[F_DONE] & irq_en;

  always_comb begin
    flg_d = (flg_q & ~clr) | set_evt;
    cap_d = cap_q;
    if (stat_rd)       cap_d = flg_q;
    else if (data_acc) cap_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      cap_q <= '0;
    end else begin
      flg_q <= flg_d;
      cap_q <= cap_d;
    end
  end

  AST_COLL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt[F_COLL] |=> flg_q[F_COLL]);  // R5

  AST_CLEAR_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && (cap_q != '0) && (set_evt == '0) |=> (flg_q & $past(cap_q)) == '0);  // R8

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !data_acc && (set_evt == '0) |=> flg_q == $past(flg_q));  // R3

  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt[F_DONE] && irq_en |=> irq || !irq_en);  // R7

endmodule

// File: rtl/spi_ctl_top.sv
module spi_ctl_top
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n_out,
  input  logic              ss_n_in
);

  ctrl_t             ctrl_q, ctrl_d;
  logic              busy, done, tick;
  logic [BYTE_W-1:0] rx_byte;
  logic [FLAG_N-1:0] flags, set_evt;
  logic              ctrl_wr, data_wr, data_rd, stat_rd;
  logic              start, coll, data_acc;

  assign ctrl_wr  = wr_en && (reg_sel == SEL_CTRL);
  assign data_wr  = wr_en && (reg_sel == SEL_DATA);
  assign data_rd  = rd_en && (reg_sel == SEL_DATA);
  assign stat_rd  = rd_en && (reg_sel == SEL_STAT);
  assign start    = data_wr && ctrl_q.sys_en && !busy;
  assign coll     = data_wr && ctrl_q.sys_en && busy;
  assign data_acc = data_rd || (data_wr && ctrl_q.sys_en);

  always_comb begin
    set_evt         = '0;
    set_evt[F_DONE] = done;
    set_evt[F_COLL] = coll;
    set_evt[F_MODF] = ctrl_q.master && !ss_n_in;
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = ctrl_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  always_comb begin
    case (reg_sel)
      SEL_CTRL: rd_data = ctrl_q;
      SEL_STAT: rd_data = {flags[F_DONE], flags[F_COLL], 1'b0, flags[F_MODF], 4'b0000};
      SEL_DATA: rd_data = rx_byte;
      default:  rd_data = '0;
    endcase
  end

  assign ss_n_out = !(busy && ctrl_q.master);

  spi_half_tick u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .rate_code (ctrl_q.rate),
    .run       (busy),
    .tick      (tick)
  );

  spi_shift_engine u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tx_byte (wr_data),
    .tick    (tick),
    .cpol    (ctrl_q.cpol),
    .cpha    (ctrl_q.cpha),
    .miso    (miso),
    .busy    (busy),
    .done    (done),
    .sck     (sck),
    .mosi    (mosi),
    .rx_byte (rx_byte)
  );

  spi_flag_unit u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (set_evt),
    .stat_rd  (stat_rd),
    .data_acc (data_acc),
    .irq_en   (ctrl_q.irq_en),
    .flags    (flags),
    .irq      (irq)
  );

  AST_DISABLED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && !ctrl_q.sys_en && !busy |=> !busy);  // R4

  AST_MODE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.master && !ss_n_in |=> flags[F_MODF]);  // R11

endmodule

// File: tb/tb_spi_ctl_top.sv
module tb_spi_ctl_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_sel;
  logic       rd_en, wr_en;
  logic [7:0] wr_data, rd_data;
  logic       irq, sck, mosi, miso, ss_n_out, ss_n_in;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  spi_ctl_top dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .sck(sck), .mosi(mosi),
    .miso(miso), .ss_n_out(ss_n_out), .ss_n_in(ss_n_in)
  );

  // {control, transmit byte, slave reply byte}
  localparam logic [23:0] VECS [6] = '{
    24'h50A53C, 24'h58817E, 24'h555AC3, 24'h5EFF00, 24'h5300FF, 24'h5D9669
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%02h exp=%02h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    reg_sel = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    reg_sel = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic int half_of(input logic [1:0] r);
    case (r)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog expired got=hung exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; reg_sel = 2'd0; rd_en = 1'b0; wr_en = 1'b0;
    wr_data = 8'h00; miso = 1'b0; ss_n_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    bus_rd(2'd1, v); chk("R1 status", v, 8'h00);
    chk("R1 sck", {7'b0, sck}, 8'h00);
    chk("R1 ss_n_out", {7'b0, ss_n_out}, 8'h01);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R2 control readback including stored-only bit
    bus_wr(2'd0, 8'hA7);
    bus_rd(2'd0, v); chk("R2 ctrl readback", v, 8'hA7);

    // table walk: R2 rates, R6 shift-out, R9 clock shape, R10 capture
    foreach (VECS[i]) begin
      logic [7:0] cw, tx, rp;
      int h;
      cw = VECS[i][23:16]; tx = VECS[i][15:8]; rp = VECS[i][7:0];
      h = half_of(cw[1:0]);
      bus_wr(2'd0, cw);
      chk("R9 sck idle", {7'b0, sck}, {7'b0, cw[3]});
      miso = rp[7];
      bus_wr(2'd2, tx);
      for (int b = 0; b < 8; b++) begin
        miso = rp[7-b];
        chk("R6 mosi bit", {7'b0, mosi}, {7'b0, tx[7-b]});
        chk("R6 ss_n_out low", {7'b0, ss_n_out}, 8'h00);
        chk("R9 sck first half", {7'b0, sck}, {7'b0, cw[3] ^ cw[2]});
        repeat (h) @(negedge clk);
        chk("R9 sck second half", {7'b0, sck}, {7'b0, ~(cw[3] ^ cw[2])});
        repeat (h) @(negedge clk);
      end
      chk("R6 ss_n_out end", {7'b0, ss_n_out}, 8'h01);
      bus_rd(2'd1, v); chk("R7 complete flag", v, 8'h80);
      bus_rd(2'd2, v); chk("R10 received byte", v, rp);
      bus_rd(2'd1, v); chk("R8 cleared", v, 8'h00);
    end

    // R5 collision during transfer at fastest rate
    bus_wr(2'd0, 8'h50);
    miso = 1'b1;
    bus_wr(2'd2, 8'hC3);
    bus_wr(2'd2, 8'h00);
    repeat (14) @(negedge clk);
    chk("R5 still busy before end", {7'b0, ss_n_out}, 8'h00);
    @(negedge clk);
    chk("R5 ends on original schedule", {7'b0, ss_n_out}, 8'h01);
    // R8 data access with no prior status read clears nothing
    bus_rd(2'd2, v); chk("R5 received byte", v, 8'hFF);
    bus_rd(2'd1, v); chk("R5 collision and complete", v, 8'hC0);
    // R8 flag set after the status read survives the clear
    ss_n_in = 1'b0;
    @(negedge clk);
    ss_n_in = 1'b1;
    bus_rd(2'd1, v); chk("R11 mode fault set", v, 8'hD0);
    bus_rd(2'd2, v);
    ss_n_in = 1'b0;
    @(negedge clk);
    ss_n_in = 1'b1;
    bus_rd(2'd1, v); chk("R8 capture from before", v, 8'h10);
    bus_rd(2'd2, v);
    bus_rd(2'd1, v); chk("R8 second clear", v, 8'h00);

    // R3 status write has no effect
    bus_wr(2'd1, 8'hFF);
    bus_rd(2'd1, v); chk("R3 status write ignored", v, 8'h00);

    // R7 interrupt request
    bus_wr(2'd0, 8'hD0);
    bus_wr(2'd2, 8'h11);
    chk("R7 irq low during transfer", {7'b0, irq}, 8'h00);
    repeat (16) @(negedge clk);
    chk("R7 irq raised", {7'b0, irq}, 8'h01);
    bus_wr(2'd0, 8'h50);
    chk("R7 irq masked", {7'b0, irq}, 8'h00);
    bus_wr(2'd0, 8'hD0);
    bus_rd(2'd1, v);
    bus_rd(2'd2, v);
    chk("R7 irq dropped after clear", {7'b0, irq}, 8'h00);

    // R4 write with controller disabled
    bus_wr(2'd0, 8'h10);
    bus_wr(2'd2, 8'h77);
    chk("R4 no frame", {7'b0, ss_n_out}, 8'h01);
    repeat (40) @(negedge clk);
    bus_rd(2'd1, v); chk("R4 no flag", v, 8'h00);

    // R12 reset during a slow transfer
    bus_wr(2'd0, 8'h5B);
    bus_wr(2'd2, 8'hE1);
    repeat (20) @(negedge clk);
    chk("R12 mid transfer frame", {7'b0, ss_n_out}, 8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R12 frame dropped", {7'b0, ss_n_out}, 8'h01);
    chk("R12 sck back to 0", {7'b0, sck}, 8'h00);
    repeat (600) @(negedge clk);
    bus_rd(2'd1, v); chk("R12 no late completion", v, 8'h00);
    bus_rd(2'd0, v); chk("R12 ctrl cleared", v, 8'h00);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule